// File: doc/BRIEF.md
# List-Driven Memory DMA Engine

This block moves bytes from memory to memory on behalf of a processor. Software places a small packed job descriptor in memory and then writes the descriptor's 20-bit address into three byte-wide registers. The write of the least significant byte starts the job. From that moment the engine holds the processor off the bus. It reads the descriptor one byte at a time and then performs either a block copy or a block fill. When the last byte has been written, it releases the processor and pulses a completion flag.

Memory is reached through a single-master synchronous port. The engine raises a request with an address, a direction and write data. The memory accepts the transfer in any cycle in which it returns ready. Read data is taken in the same cycle as ready. A copy picks its direction from the two addresses, so a region moved up or down by a few bytes arrives intact.

Top module: `lst_dma`

## Requirements
- R1: A register write with offset 2 loads the bank byte (address bits 19:16 from data bits 3:0), and offset 1 loads address bits 15:8. Neither of these writes starts a job. A write to offset 0 starts a job whose list address is {bank, high byte, written data}.
- R2: `cpu_hold` rises in the cycle after the starting write. It stays high through the acceptance of the last memory write of the job and is low in the following cycle. `mem_req` is never high while `cpu_hold` is low.
- R3: The descriptor is read first, as exactly 11 accepted reads at the list address plus 0, 1, ..., 10, in increasing order. No write happens before the 11th read.
- R4: The descriptor layout is as follows. Byte 0 is the command (0x00 = copy, 0x03 = fill). Bytes 1–2 are the length, low byte first. Bytes 3–5 are the source and bytes 6–8 the destination, each low byte first. Address bits above bit 19 are ignored. Bytes 9 and 10 are read but have no effect.
- R5: A copy of N bytes leaves destination byte i equal to the value source byte i held before the job, for every i < N, even when the regions overlap in either direction. Each byte costs one read followed by one write.
- R6: A fill writes descriptor byte 3 (the low source byte) to every destination byte and performs no read after the descriptor.
- R7: A length field of 0 moves 65536 bytes.
- R8: Any command value other than 0x00 or 0x03 performs no memory write. The job still ends with `cpu_hold` falling and a `done` pulse.
- R9: `done` is high for exactly one cycle per job, and that cycle is the first cycle in which `cpu_hold` is low again.
- R10: Register writes while `cpu_hold` is high are ignored. They neither start a job nor change the stored bank or high byte.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and (for writes) `mem_wdata` hold their values into the next cycle.
- R12: A job of N bytes issues exactly N writes, and each of them falls within destination .. destination+N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 low, 1 high, 2 bank) |
| reg_wdata | input | 8 | Register write data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory accepts the current request |
| cpu_hold | output | 1 | Processor held off while a job runs |
| done | output | 1 | One-cycle job completion pulse |

## Verification
A corrupted fetch index or list pointer appears within the first eleven accepted reads: the read address leaves the list+k sequence, and the bench catches it in that cycle. A wrong direction choice or pointer step shows only in memory contents after an overlapping copy. It is therefore caught once `done` arrives, by comparing the destination against a snapshot taken before the start. A remaining-count error shows as a write count that differs from N, or as a write outside the destination window at the first stray write. An early or missing release shows in the cycle `done` appears. Stalls of one and two cycles on the memory port expose any request that changes before it is accepted.

// File: rtl/lst_dma_pkg.sv
// Package: shared constants and types of the list-driven DMA engine.
// Assumes byte-wide memory and an 11-byte job descriptor.
package lst_dma_pkg;
    localparam int DESC_BYTES = 11;          // bytes read per descriptor
    localparam int IDX_W      = 4;           // width of the descriptor byte index
    localparam int LEN_W      = 16;          // length field is two bytes
    localparam logic [7:0] CMD_COPY = 8'h00;
    localparam logic [7:0] CMD_FILL = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PLAN,
        ST_READ,
        ST_WRITE
    } dma_state_t;
endpackage

// File: rtl/lst_dma_regs.sv
// Module: list-address registers and start trigger.
// Holds the bank and high bytes. The low byte is never stored: its write is
// the trigger, and it is passed straight through with the start pulse.
// Assumes ADDR_W lies between 17 and 24.
module lst_dma_regs #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              busy,
    output logic              start,
    output logic [ADDR_W-1:0] list_addr
);
    localparam int BANK_W = ADDR_W - 16;

    logic [BANK_W-1:0] r_bank;
    logic [7:0]        r_high;

    // Capture bank and high bytes while idle; writes during a job are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_bank <= '0;
            r_high <= '0;
        end else if (reg_we && !busy) begin
            if (reg_addr == 2'd2) r_bank <= reg_wdata[BANK_W-1:0];
            if (reg_addr == 2'd1) r_high <= reg_wdata;
        end
    end

    // Start fires on an idle write of offset 0, with that byte as address bits 7:0.
    always_comb begin
        start     = reg_we && (reg_addr == 2'd0) && !busy;
        list_addr = {r_bank, r_high, reg_wdata};
    end
endmodule

// File: rtl/lst_dma_desc.sv
// Module: descriptor capture.
// Stores descriptor bytes 0..8 as they stream in from memory. Only the
// address bits the engine uses are kept. Bytes 9 and 10 are read by the
// controller but not stored here.
module lst_dma_desc
    import lst_dma_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [7:0]        rdata,
    output logic [7:0]        d_cmd,
    output logic [LEN_W-1:0]  d_len,
    output logic [ADDR_W-1:0] d_src,
    output logic [ADDR_W-1:0] d_dst
);
    localparam int FIELD_BYTES = 9;
    localparam int TOP_W       = ADDR_W - 16;

    for (genvar i = 0; i < FIELD_BYTES; i++) begin : g_byte
        localparam int BW = (i == 5 || i == 8) ? TOP_W : 8;
        logic [BW-1:0] q;

        // Latch this descriptor byte when its index is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      q <= '0;
            else if (cap_en && (cap_idx == IDX_W'(i)))       q <= rdata[BW-1:0];
        end

        if (i == 0) begin : g_cmd
            assign d_cmd = q;
        end else if (i <= 2) begin : g_len
            assign d_len[(i-1)*8 +: 8] = q;
        end else if (i <= 5) begin : g_src
            assign d_src[(i-3)*8 +: BW] = q;
        end else begin : g_dst
            assign d_dst[(i-6)*8 +: BW] = q;
        end
    end
endmodule

// File: rtl/lst_dma_ctrl.sv
// Module: job sequencer.
// Walks the descriptor fetch, chooses the copy direction, and then runs one
// read plus one write per copied byte, or one write per filled byte.
// Assumes a request is accepted in any cycle with mem_ready high, with
// read data valid in that same cycle.
module lst_dma_ctrl
    import lst_dma_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] list_addr,
    input  logic [7:0]        d_cmd,
    input  logic [LEN_W-1:0]  d_len,
    input  logic [ADDR_W-1:0] d_src,
    input  logic [ADDR_W-1:0] d_dst,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_BYTES - 1);

    dma_state_t        state;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] lptr, sptr, dptr;
    logic [CNT_W-1:0]  remain;
    logic [7:0]        hold_byte;
    logic              down, fill_mode, done_q;
    logic [CNT_W-1:0]  rem_init;
    logic [ADDR_W-1:0] span;
    logic              accept;

    // Byte count of the job (0 means a full 64 KiB) and the offset of its last byte.
    always_comb begin
        rem_init = (d_len == '0) ? (CNT_W'(1) << LEN_W) : {1'b0, d_len};
        span     = ADDR_W'(rem_init - CNT_W'(1));
    end

    // Memory request decode from the current state.
    always_comb begin
        mem_req   = (state == ST_FETCH) || (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        unique case (state)
            ST_FETCH: mem_addr = lptr;
            ST_READ:  mem_addr = sptr;
            ST_WRITE: mem_addr = dptr;
            default:  mem_addr = '0;
        endcase
        mem_wdata = fill_mode ? d_src[7:0] : hold_byte;
        accept    = mem_req && mem_ready;
        cap_en    = (state == ST_FETCH) && mem_ready;
        cap_idx   = idx;
        busy      = (state != ST_IDLE);
        done      = done_q;
    end

    // Sequencer: fetch, plan, then move bytes until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            lptr      <= '0;
            sptr      <= '0;
            dptr      <= '0;
            remain    <= '0;
            hold_byte <= '0;
            down      <= 1'b0;
            fill_mode <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        lptr  <= list_addr;
                        idx   <= '0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (accept) begin
                        lptr <= lptr + ADDR_W'(1);
                        idx  <= idx + IDX_W'(1);
                        if (idx == LAST_IDX) state <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    remain <= rem_init;
                    if (d_cmd == CMD_COPY) begin
                        fill_mode <= 1'b0;
                        down      <= (d_src < d_dst);
                        sptr      <= (d_src < d_dst) ? d_src + span : d_src;
                        dptr      <= (d_src < d_dst) ? d_dst + span : d_dst;
                        state     <= ST_READ;
                    end else if (d_cmd == CMD_FILL) begin
                        fill_mode <= 1'b1;
                        down      <= 1'b0;
                        dptr      <= d_dst;
                        state     <= ST_WRITE;
                    end else begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (accept) begin
                        hold_byte <= mem_rdata;
                        sptr      <= down ? sptr - ADDR_W'(1) : sptr + ADDR_W'(1);
                        state     <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (accept) begin
                        remain <= remain - CNT_W'(1);
                        dptr   <= down ? dptr - ADDR_W'(1) : dptr + ADDR_W'(1);
                        if (remain == CNT_W'(1)) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= fill_mode ? ST_WRITE : ST_READ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lst_dma.sv
// Module: list-driven memory DMA engine, top level.
// Connects the list-address registers, the descriptor capture and the
// sequencer. Assumes a single memory master (this block) while cpu_hold is high.
module lst_dma
    import lst_dma_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic              cpu_hold,
    output logic              done
);
    logic              start;
    logic [ADDR_W-1:0] list_addr;
    logic              cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic [7:0]        d_cmd;
    logic [LEN_W-1:0]  d_len;
    logic [ADDR_W-1:0] d_src, d_dst;
    logic              busy;

    lst_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .start(start), .list_addr(list_addr)
    );

    lst_dma_desc #(.ADDR_W(ADDR_W)) u_desc (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
        .rdata(mem_rdata), .d_cmd(d_cmd), .d_len(d_len), .d_src(d_src), .d_dst(d_dst)
    );

    lst_dma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .list_addr(list_addr),
        .d_cmd(d_cmd), .d_len(d_len), .d_src(d_src), .d_dst(d_dst),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .cap_en(cap_en), .cap_idx(cap_idx),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done)
    );

    // The processor is held exactly while the sequencer is away from idle.
    assign cpu_hold = busy;
endmodule

// File: rtl/lst_dma_chk.sv
// Module: protocol checker for lst_dma, bound to every instance.
// Observes ports only.
module lst_dma_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_ready,
    input logic              cpu_hold,
    input logic              done
);
    p_start_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0 && !cpu_hold) |=> cpu_hold);

    p_req_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_hold);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cpu_hold && $past(cpu_hold)));

    p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && (!mem_we || $stable(mem_wdata))));
endmodule

bind lst_dma lst_dma_chk #(.ADDR_W(ADDR_W)) u_lst_dma_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .cpu_hold(cpu_hold), .done(done)
);

// File: tb/test_lst_dma.sv
`timescale 1ns/1ps
// Bench: a table of jobs walked by one loop, then directed corner cases.
module test_lst_dma;
    localparam int AW = 20;
    localparam int unsigned AMASK = 32'h000F_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          cpu_hold, done;

    always #10 clk = ~clk;   // 50 MHz

    lst_dma #(.ADDR_W(AW)) i_lst_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .cpu_hold(cpu_hold), .done(done)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] mem [int unsigned];

    // Unwritten memory reads as a fixed address pattern.
    function automatic logic [7:0] peek(int unsigned a);
        int unsigned k = a & AMASK;
        if (mem.exists(k)) return mem[k];
        return 8'((k * 7) + 3);
    endfunction

    task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model and monitor ----------------
    int stall_mode = 0, cyc = 0;
    int rd_cnt, wr_cnt, fetch_err, fill_rd, early_wr, range_err, stab_err;
    logic [AW-1:0] mon_list, mon_dlo;
    int unsigned   mon_len;
    bit            mon_fill;
    bit            pend = 0, p_we = 0;
    logic [AW-1:0] p_addr = '0;
    logic [7:0]    p_data = '0;

    always @(negedge clk) begin
        bit r;
        cyc++;
        case (stall_mode)
            1:       r = (cyc % 2) == 0;
            2:       r = (cyc % 3) == 0;
            default: r = 1'b1;
        endcase
        if (pend && (mem_req !== 1'b1 || mem_addr !== p_addr || mem_we !== p_we ||
                     (p_we && mem_wdata !== p_data))) stab_err++;
        pend   = (mem_req === 1'b1) && !r;
        p_addr = mem_addr; p_we = mem_we; p_data = mem_wdata;
        mem_ready = r;
        mem_rdata = peek(int'(mem_addr));
        if (mem_req === 1'b1 && r) begin
            if (!mem_we) begin
                if (rd_cnt < 11 && mem_addr != AW'(mon_list + AW'(rd_cnt))) fetch_err++;
                if (rd_cnt >= 11 && mon_fill) fill_rd++;
                rd_cnt++;
            end else begin
                if (rd_cnt < 11) early_wr++;
                if (((int'(mem_addr) - int'(mon_dlo)) & AMASK) >= mon_len) range_err++;
                mem[int'(mem_addr)] = mem_wdata;
                wr_cnt++;
            end
        end
    end

    // ---------------- job helpers ----------------
    logic [7:0]  g_exp [$];
    int unsigned g_dst, g_n;
    logic [7:0]  g_cmd;

    task automatic reg_write(input logic [1:0] off, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = off; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic prep_start(input logic [19:0] list, input logic [7:0] cmd, input logic [15:0] len,
                              input logic [23:0] src, input logic [23:0] dst, input int stall,
                              input bit only_low);
        int unsigned s = int'(src) & AMASK;
        int unsigned nb = (len == 0) ? 65536 : int'(len);
        logic [7:0] db [11];
        db = '{cmd, len[7:0], len[15:8], src[7:0], src[15:8], src[23:16],
               dst[7:0], dst[15:8], dst[23:16], 8'h00, 8'h00};
        for (int i = 0; i < 11; i++) mem[(int'(list) + i) & AMASK] = db[i];
        g_dst = int'(dst) & AMASK;
        g_cmd = cmd;
        g_n   = (cmd == 8'h00 || cmd == 8'h03) ? nb : 0;
        g_exp.delete();
        for (int unsigned i = 0; i < g_n; i++)
            g_exp.push_back((cmd == 8'h03) ? src[7:0] : peek(s + i));
        rd_cnt = 0; wr_cnt = 0; fetch_err = 0; fill_rd = 0; early_wr = 0;
        range_err = 0; stab_err = 0;
        mon_list = list; mon_dlo = AW'(g_dst); mon_len = g_n; mon_fill = (cmd == 8'h03);
        stall_mode = stall;
        if (!only_low) begin
            reg_write(2'd2, {4'h0, list[19:16]});
            reg_write(2'd1, list[15:8]);
            #1;
            chk(cpu_hold === 1'b0, "R1", "offsets 1/2 started a job", 64'(cpu_hold), 0);
        end
        reg_write(2'd0, list[7:0]);
        #1;
        chk(cpu_hold === 1'b1, "R2", "hold after start", 64'(cpu_hold), 1);
        chk(mem_req === 1'b1 && mem_addr === list, "R1", "first fetch address",
            64'(mem_addr), 64'(list));
    endtask

    task automatic finish_job(input string tag);
        int t = 0, bad = 0, first = -1;
        while (done !== 1'b1 && t < 150000) begin
            @(negedge clk); #1; t++;
        end
        chk(done === 1'b1, "R9", "done seen", 64'(done), 1);
        chk(cpu_hold === 1'b0, "R9", "hold low with done", 64'(cpu_hold), 0);
        chk(wr_cnt == int'(g_n), "R12", "write count", 64'(wr_cnt), 64'(g_n));
        chk(range_err == 0, "R12", "writes outside window", 64'(range_err), 0);
        chk(fetch_err == 0 && rd_cnt >= 11, "R3", "descriptor read order", 64'(fetch_err), 0);
        chk(early_wr == 0, "R3", "write before fetch end", 64'(early_wr), 0);
        chk(stab_err == 0, "R11", "request changed while stalled", 64'(stab_err), 0);
        if (g_cmd == 8'h00)
            chk(rd_cnt == 11 + int'(g_n), "R5", "copy read count", 64'(rd_cnt), 64'(11 + g_n));
        else
            chk(fill_rd == 0 && rd_cnt == 11, "R6", "reads beyond descriptor", 64'(rd_cnt), 11);
        @(negedge clk); #1;
        chk(done === 1'b0, "R9", "done width", 64'(done), 0);
        for (int unsigned i = 0; i < g_n; i++)
            if (peek(g_dst + i) !== g_exp[i]) begin
                bad++;
                if (first < 0) first = int'(i);
            end
        chk(bad == 0, tag, "destination contents", 64'(bad), 0);
        if (bad != 0) $display("  first bad offset %0d", first);
    endtask

    // ---------------- table of jobs ----------------
    localparam int NV = 6;
    localparam logic [19:0] V_LIST [NV] = '{20'h00100, 20'h40200, 20'h7FFF0, 20'h00300, 20'h00400, 20'h00500};
    localparam logic [7:0]  V_CMD  [NV] = '{8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 8'h00};
    localparam logic [15:0] V_LEN  [NV] = '{16'd16, 16'd40, 16'd40, 16'd100, 16'd8, 16'd1};
    localparam logic [23:0] V_SRC  [NV] = '{24'h001000, 24'h030002, 24'h030108, 24'h0000A5, 24'hF10000, 24'h006000};
    localparam logic [23:0] V_DST  [NV] = '{24'h002000, 24'h030008, 24'h030100, 24'h005000, 24'h011000, 24'h006001};
    localparam int          V_STL  [NV] = '{0, 1, 2, 1, 0, 2};

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int quiet;
        repeat (4) @(negedge clk);
        #1;
        chk(cpu_hold === 1'b0 && mem_req === 1'b0, "R2", "idle in reset", 64'({cpu_hold, mem_req}), 0);
        chk(done === 1'b0, "R9", "no done in reset", 64'(done), 0);
        @(negedge clk); rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            prep_start(V_LIST[v], V_CMD[v], V_LEN[v], V_SRC[v], V_DST[v], V_STL[v], 1'b0);
            finish_job(v == 4 ? "R4" : (V_CMD[v] == 8'h03 ? "R6" : "R5"));
        end

        // R10: register writes during a job have no effect
        prep_start(20'h00600, 8'h03, 16'd200, 24'h000077, 24'h008000, 1, 1'b0);
        repeat (5) @(negedge clk);
        reg_write(2'd2, 8'h0F);
        reg_write(2'd1, 8'hAA);
        reg_write(2'd0, 8'h55);
        finish_job("R10");
        quiet = 0;
        repeat (20) begin
            @(negedge clk); #1;
            if (cpu_hold !== 1'b0 || mem_req !== 1'b0) quiet++;
        end
        chk(quiet == 0, "R10", "activity after busy writes", 64'(quiet), 0);
        // stored bank/high must still be 0x0/0x06
        prep_start(20'h00680, 8'h03, 16'd4, 24'h000011, 24'h009000, 0, 1'b1);
        finish_job("R10");

        // R8: unknown command writes nothing
        prep_start(20'h00700, 8'h05, 16'd10, 24'h001000, 24'h00A000, 2, 1'b0);
        finish_job("R8");

        // R7: length 0 fills 65536 bytes
        prep_start(20'h00800, 8'h03, 16'd0, 24'h00003C, 24'h020000, 0, 1'b0);
        finish_job("R7");

        summary();
        $finish;
    end
endmodule